// File: doc/BRIEF.md
# Byte Shift, Rotate and Single-Bit Unit

This combinational unit takes one byte and one operation code, and returns the transformed byte, a writeback strobe and a new flag nibble, all in the same cycle. It covers four rotates (left or right, each either circular or through the carry flag), an arithmetic left shift, arithmetic and logical right shifts, a nibble exchange, and three single-bit operations that test, clear or set the bit chosen by a 3-bit index. A processor datapath places it beside its adder. The datapath supplies the register or memory byte and the current flags, then writes back the result when the strobe is high. Instruction decoding and read-modify-write sequencing belong to the surrounding logic.

A short-form input selects the accumulator-only rotate variants. These variants always report a zero flag of 0. The regular forms derive the zero flag from the result. The flag nibble is packed as Z at bit 3, N at bit 2, H at bit 1 and C at bit 0, on both input and output. The unit has no state machine and no clock. Each operation code maps directly to one output combination, so there are no states or transitions to list.

Top module: `sru_core`

## Requirements
- R1: Operation code 0 (circular left) returns {d[6:0], d[7]} with C = d[7]. Operation code 1 (left through carry) returns {d[6:0], C_in} with C = d[7].
- R2: Operation code 2 (circular right) returns {d[0], d[7:1]} with C = d[0]. Operation code 3 (right through carry) returns {C_in, d[7:1]} with C = d[0].
- R3: Operation code 4 (arithmetic left shift) returns {d[6:0], 0} with C = d[7].
- R4: Operation code 5 (arithmetic right shift) returns {d[7], d[7:1]}. Operation code 6 (logical right shift) returns {0, d[7:1]}. Both set C = d[0].
- R5: For codes 0 to 6 with the short form low, the output flags are Z = (result == 0), N = 0 and H = 0.
- R6: When the short form is high on codes 0 to 3, Z, N and H are all 0 and C comes from the bit shifted out. The short form has no effect on codes 4 to 15.
- R7: Operation code 7 exchanges the two nibbles, sets Z = (result == 0), and clears N, H and C.
- R8: Operation code 8 (bit test) sets Z = NOT d[idx], N = 0 and H = 1, passes C_in through, returns the operand unchanged, and holds writeback low.
- R9: Operation code 9 forces bit idx of the result to 0 and operation code 10 forces it to 1. All other bits keep their values, and the flags equal the input flags.
- R10: Writeback is high for codes 0 to 7, 9 and 10. For the unused codes 11 to 15, writeback is low, the result equals the operand, and the flags equal the input flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 4 | Operation code, 0 to 10 defined |
| operand | input | 8 | Byte to transform |
| bit_idx | input | 3 | Bit chosen by test, clear and set |
| short_form | input | 1 | Selects accumulator-only rotate flag behaviour |
| flags_in | input | 4 | Current flags {Z,N,H,C} |
| result | output | 8 | Transformed byte |
| wr_en | output | 1 | Writeback strobe |
| flags_out | output | 4 | Updated flags {Z,N,H,C} |

## Verification
Two controls can overlap on one input vector. The short-form select can be high while the operation code names a shift, the swap or a bit operation. The bit index is always present, even when the code names a shift or rotate. The bench drives every operation code with the short form both high and low, and with a nonzero index. Each output is compared with a model that lets the short form act only on codes 0 to 3 and the index act only on codes 8 to 10. Operands include all-zero, all-one, single-bit and alternating patterns. This set exercises both fill bits and the boundaries of the zero flag.

// File: rtl/sru_pkg.sv
package sru_pkg;

    typedef enum logic [3:0] {
        OP_ROL_CIRC  = 4'd0,
        OP_ROL_CARRY = 4'd1,
        OP_ROR_CIRC  = 4'd2,
        OP_ROR_CARRY = 4'd3,
        OP_SHL_ARITH = 4'd4,
        OP_SHR_ARITH = 4'd5,
        OP_SHR_LOGIC = 4'd6,
        OP_NIB_SWAP  = 4'd7,
        OP_BIT_TEST  = 4'd8,
        OP_BIT_CLEAR = 4'd9,
        OP_BIT_SET   = 4'd10
    } sru_op_e;

    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } sru_flags_t;

endpackage

// File: rtl/sru_rotate_shift.sv
module sru_rotate_shift
    import sru_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [3:0]        op_code,
    input  logic [DATA_W-1:0] din,
    input  logic              carry_in,
    output logic [DATA_W-1:0] dout,
    output logic              carry_out,
    output logic              is_rotate
);
    localparam int HALF_W = DATA_W / 2;

    always_comb begin
        dout      = din;
        carry_out = carry_in;
        is_rotate = 1'b0;
        case (op_code)
            OP_ROL_CIRC: begin
                dout      = {din[DATA_W-2:0], din[DATA_W-1]};
                carry_out = din[DATA_W-1];
                is_rotate = 1'b1;
            end
            OP_ROL_CARRY: begin
                dout      = {din[DATA_W-2:0], carry_in};
                carry_out = din[DATA_W-1];
                is_rotate = 1'b1;
            end
            OP_ROR_CIRC: begin
                dout      = {din[0], din[DATA_W-1:1]};
                carry_out = din[0];
                is_rotate = 1'b1;
            end
            OP_ROR_CARRY: begin
                dout      = {carry_in, din[DATA_W-1:1]};
                carry_out = din[0];
                is_rotate = 1'b1;
            end
            OP_SHL_ARITH: begin
                dout      = {din[DATA_W-2:0], 1'b0};
                carry_out = din[DATA_W-1];
            end
            OP_SHR_ARITH: begin
                dout      = {din[DATA_W-1], din[DATA_W-1:1]};
                carry_out = din[0];
            end
            OP_SHR_LOGIC: begin
                dout      = {1'b0, din[DATA_W-1:1]};
                carry_out = din[0];
            end
            OP_NIB_SWAP: begin
                dout      = {din[HALF_W-1:0], din[DATA_W-1:HALF_W]};
                carry_out = 1'b0;
            end
            default: begin
                dout      = din;
                carry_out = carry_in;
            end
        endcase
    end
endmodule

// File: rtl/sru_bit_ops.sv
module sru_bit_ops #(
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] din,
    input  logic [IDX_W-1:0]  idx,
    output logic              picked,
    output logic [DATA_W-1:0] cleared,
    output logic [DATA_W-1:0] setted
);
    logic [DATA_W-1:0] onehot;

    for (genvar i = 0; i < DATA_W; i++) begin : g_mask
        assign onehot[i] = (idx == IDX_W'(i));
    end

    assign picked  = |(din & onehot);
    assign cleared = din & ~onehot;
    assign setted  = din | onehot;
endmodule

// File: rtl/sru_core.sv
module sru_core
    import sru_pkg::*;
(
    input  logic [3:0] op_sel,
    input  logic [7:0] operand,
    input  logic [2:0] bit_idx,
    input  logic       short_form,
    input  logic [3:0] flags_in,
    output logic [7:0] result,
    output logic       wr_en,
    output logic [3:0] flags_out
);
    localparam int DATA_W = 8;

    sru_flags_t        fin;
    sru_flags_t        fout;
    logic [DATA_W-1:0] shift_res;
    logic              shift_c;
    logic              rot_kind;
    logic              bit_val;
    logic [DATA_W-1:0] clr_res;
    logic [DATA_W-1:0] set_res;

    assign fin = sru_flags_t'(flags_in);

    sru_rotate_shift #(.DATA_W(DATA_W)) u_shift (
        .op_code  (op_sel),
        .din      (operand),
        .carry_in (fin.c),
        .dout     (shift_res),
        .carry_out(shift_c),
        .is_rotate(rot_kind)
    );

    sru_bit_ops #(.DATA_W(DATA_W)) u_bits (
        .din    (operand),
        .idx    (bit_idx),
        .picked (bit_val),
        .cleared(clr_res),
        .setted (set_res)
    );

    always_comb begin
        result = operand;
        wr_en  = 1'b0;
        fout   = fin;
        case (op_sel)
            OP_ROL_CIRC, OP_ROL_CARRY, OP_ROR_CIRC, OP_ROR_CARRY,
            OP_SHL_ARITH, OP_SHR_ARITH, OP_SHR_LOGIC, OP_NIB_SWAP: begin
                result = shift_res;
                wr_en  = 1'b1;
                fout.z = (shift_res == '0) && !(rot_kind && short_form);
                fout.n = 1'b0;
                fout.h = 1'b0;
                fout.c = shift_c;
            end
            OP_BIT_TEST: begin
                fout.z = ~bit_val;
                fout.n = 1'b0;
                fout.h = 1'b1;
            end
            OP_BIT_CLEAR: begin
                result = clr_res;
                wr_en  = 1'b1;
            end
            OP_BIT_SET: begin
                result = set_res;
                wr_en  = 1'b1;
            end
            default: ;
        endcase
    end

    assign flags_out = fout;

    always_comb begin
        if (op_sel == OP_BIT_TEST) begin
            assert_bit_test_no_write_R8: assert (!wr_en && result == operand)
                else $error("bit test wrote back");
            assert_bit_test_keep_c_R8: assert (flags_out[0] == flags_in[0])
                else $error("bit test altered carry");
        end
        if (op_sel == OP_BIT_CLEAR || op_sel == OP_BIT_SET) begin
            assert_bit_edit_flags_R9: assert (flags_out == flags_in)
                else $error("bit edit altered flags");
        end
        if (short_form && op_sel <= 4'd3) begin
            assert_short_rot_zero_R6: assert (flags_out[3:1] == 3'b000)
                else $error("short rotate flags not cleared");
        end
        if (op_sel == OP_NIB_SWAP) begin
            assert_swap_c_clear_R7: assert (!flags_out[0] && wr_en)
                else $error("swap carry not cleared");
        end
        if (op_sel > 4'd10) begin
            assert_unused_inert_R10: assert (!wr_en && flags_out == flags_in)
                else $error("unused code had effect");
        end
    end
endmodule

// File: tb/sru_core_tb_top.sv
module sru_core_tb_top;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [3:0] op_sel;
    logic [7:0] operand;
    logic [2:0] bit_idx;
    logic       short_form;
    logic [3:0] flags_in;
    logic [7:0] result;
    logic       wr_en;
    logic [3:0] flags_out;

    sru_core dut_i (
        .op_sel(op_sel), .operand(operand), .bit_idx(bit_idx),
        .short_form(short_form), .flags_in(flags_in),
        .result(result), .wr_en(wr_en), .flags_out(flags_out)
    );

    typedef struct {
        logic [12:0] exp;
        string       req;
    } item_t;

    item_t q[$];
    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    function automatic string req_of(int op, bit sf);
        if (op == 0 || op == 1) return sf ? "R1/R6" : "R1/R5";
        if (op == 2 || op == 3) return sf ? "R2/R6" : "R2/R5";
        if (op == 4) return "R3/R5";
        if (op == 5 || op == 6) return "R4/R5";
        if (op == 7) return "R7";
        if (op == 8) return "R8";
        if (op == 9 || op == 10) return "R9";
        return "R10";
    endfunction

    // expected {result, wr_en, flags}
    function automatic logic [12:0] model(int op, logic [7:0] d, int idx, bit sf, logic [3:0] fi);
        logic [7:0] r;
        logic c, z, w;
        logic [3:0] f;
        logic cin;
        cin = fi[0];
        r = d; c = cin; w = 1'b1; f = fi;
        case (op)
            0: begin r = {d[6:0], d[7]}; c = d[7]; end
            1: begin r = {d[6:0], cin};  c = d[7]; end
            2: begin r = {d[0], d[7:1]}; c = d[0]; end
            3: begin r = {cin, d[7:1]};  c = d[0]; end
            4: begin r = {d[6:0], 1'b0}; c = d[7]; end
            5: begin r = {d[7], d[7:1]}; c = d[0]; end
            6: begin r = {1'b0, d[7:1]}; c = d[0]; end
            7: begin r = {d[3:0], d[7:4]}; c = 1'b0; end
            8: begin w = 1'b0; end
            9: begin r[idx] = 1'b0; end
            10: begin r[idx] = 1'b1; end
            default: w = 1'b0;
        endcase
        if (op <= 7) begin
            z = (r == 8'h00) && !(sf && op <= 3);
            f = {z, 1'b0, 1'b0, c};
        end else if (op == 8) begin
            f = {~d[idx], 1'b0, 1'b1, cin};
        end
        return {r, w, f};
    endfunction

    task automatic drive(int op, logic [7:0] d, int idx, bit sf, logic [3:0] fi);
        item_t it;
        @(posedge clk);
        #1;
        op_sel = 4'(op); operand = d; bit_idx = 3'(idx);
        short_form = sf; flags_in = fi;
        it.exp = model(op, d, idx, sf, fi);
        it.req = req_of(op, sf);
        q.push_back(it);
    endtask

    always @(negedge clk) begin
        if (q.size() > 0) begin
            item_t it;
            logic [12:0] act;
            it  = q.pop_front();
            act = {result, wr_en, flags_out};
            n_checks++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s op=%0d d=%h idx=%0d sf=%0b fi=%b: actual res=%h wr=%0b fl=%b expected res=%h wr=%0b fl=%b",
                         it.req, op_sel, operand, bit_idx, short_form, flags_in,
                         act[12:5], act[4], act[3:0], it.exp[12:5], it.exp[4], it.exp[3:0]);
            end
        end
    end

    initial begin
        op_sel = '0; operand = '0; bit_idx = '0; short_form = 1'b0; flags_in = '0;
        // idle vector: zero operand circular left, zero flag set (R5)
        drive(0, 8'h00, 0, 1'b0, 4'h0);
        foreach (q[i]) ;
        for (int op = 0; op < 16; op++) begin
            for (int k = 0; k < 7; k++) begin
                logic [7:0] d;
                case (k)
                    0: d = 8'h00; 1: d = 8'h80; 2: d = 8'h01; 3: d = 8'hA5;
                    4: d = 8'h5A; 5: d = 8'hFF; default: d = 8'h3C;
                endcase
                for (int fsel = 0; fsel < 4; fsel++) begin
                    for (int sf = 0; sf < 2; sf++) begin
                        if (op >= 8 && op <= 10) begin
                            for (int idx = 0; idx < 8; idx++)
                                drive(op, d, idx, sf[0], 4'(fsel * 5));
                        end else begin
                            drive(op, d, 5, sf[0], 4'(fsel * 5));
                        end
                    end
                end
            end
        end
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #900000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule